// File: doc/BRIEF.md
# Virtual-Tag Cache Alias Controller

This block is the tag and control path of a set-associative cache that is both indexed and tagged by virtual address. Every tag entry records an address-space context number, so lines from different address spaces can live side by side and a context switch does not force a flush. A lookup compares the request's virtual tag and context against every way of the indexed set and reports a hit or a miss.

On a miss, the controller asks an external translation port for the real address. It then searches the set for any valid line that holds the same real line under another virtual name, and removes that alias before the new line is installed. If the alias is dirty, its write-back is issued first, using the real address stored in the tag. Fill and write-back are request/acknowledge handshakes. The data array, the translation unit and the memory side lie outside the block.

A separate flush input removes every line of one context. It walks the sets one by one and writes back dirty lines before dropping them.

Top module: `vtag_alias_ctrl`

## Requirements
- R1: Address bits 4..0 take no part in matching. Bits 11..5 pick one of 128 sets, so the same tag with a different value in bits 11..5 addresses a different set.
- R2: A lookup hits only on a valid entry whose upper 20 virtual-address bits and context both equal the request's. A hit response appears on the second rising edge after the request is accepted, with resp_hit high and the matching way.
- R3: One virtual address under two contexts occupies two separate entries, and each context then hits its own way.
- R4: On a miss the controller holds xlate_req high, with xlate_vaddr equal to the request address, until xlate_ack arrives.
- R5: After translation, any valid way of the set that holds the same real tag is invalidated before the fill. That way is then used as the fill target.
- R6: A dirty line that is evicted raises wb_req with wb_raddr = {stored real tag, set index, 5'b0}. The line is invalidated only after wb_ack. A clean line raises no write-back.
- R7: When no alias exists, the fill target is the lowest-numbered invalid way. If all ways are valid, it is the set's round-robin pointer. The pointer starts at way 0 and advances by one, modulo the way count, on every fill into that set.
- R8: A store that hits marks the line dirty, so a later eviction of that line writes it back.
- R9: req_ready is low from the cycle after a request is accepted until that request's response has been given, and also while a flush runs.
- R10: A flush for a given context invalidates every entry of that context in all sets, writing back the dirty ones. Entries of other contexts stay valid.
- R11: A fill raises fill_req with fill_raddr = {translated real tag, set index, 5'b0} and fill_way equal to the target way. After fill_ack, a response with resp_hit low and resp_way equal to the target way follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_vaddr | input | 32 | Request virtual address |
| req_ctx | input | 8 | Request context number |
| req_store | input | 1 | Request is a store |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Response was a hit |
| resp_way | output | WAY_W | Way that was hit or filled |
| xlate_req | output | 1 | Translation request |
| xlate_vaddr | output | 32 | Address to translate |
| xlate_ack | input | 1 | Translation result valid |
| xlate_raddr | input | 32 | Translated real address |
| wb_req | output | 1 | Write-back request |
| wb_raddr | output | 32 | Real line address to write back |
| wb_ack | input | 1 | Write-back accepted |
| fill_req | output | 1 | Line fill request |
| fill_raddr | output | 32 | Real line address to fetch |
| fill_way | output | WAY_W | Way being filled |
| fill_ack | input | 1 | Fill complete |
| flush_req | input | 1 | Start a context flush |
| flush_ctx | input | 8 | Context to flush |

## Verification
The assertions check on every cycle that each handshake request stays high with a stable address until it is acknowledged. They also check that a lookup never matches more than one way, that accepting a request drops req_ready, and that no alias of the incoming real line is still valid when a fill completes. The bench scenarios show the choices that depend on history: alias reuse of a way, lowest-invalid against round-robin victim choice, dirty marking by a store hit and the write-back it later causes, separation by context, and the way a flush keeps other contexts' lines.

// File: rtl/vtag_pkg.sv
package vtag_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_XLATE,
    ST_ALIAS,
    ST_WB,
    ST_FILL,
    ST_DONE,
    ST_FLUSH
  } ctl_state_t;

  typedef enum logic [1:0] {
    TS_NONE,
    TS_INVAL,
    TS_DIRTY,
    TS_INSTALL
  } ts_op_t;

endpackage

// File: rtl/vtag_tag_store.sv
module vtag_tag_store
  import vtag_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int IDX_W = 7,
  parameter int TAG_W = 20,
  parameter int CTX_W = 8,
  localparam int SETS  = 1 << IDX_W,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [IDX_W-1:0]            rd_set,
  output logic [WAYS-1:0]             rd_valid,
  output logic [WAYS-1:0]             rd_dirty,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_vtag,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_rtag,
  output logic [WAYS-1:0][CTX_W-1:0]  rd_ctx,
  input  ts_op_t                      wr_op,
  input  logic [IDX_W-1:0]            wr_set,
  input  logic [WAY_W-1:0]            wr_way,
  input  logic [TAG_W-1:0]            wr_vtag,
  input  logic [TAG_W-1:0]            wr_rtag,
  input  logic [CTX_W-1:0]            wr_ctx,
  input  logic                        wr_dirty
);

  logic [SETS-1:0][WAYS-1:0] valid_q;
  logic [SETS-1:0][WAYS-1:0] dirty_q;
  logic [TAG_W-1:0]          vtag_q [SETS][WAYS];
  logic [TAG_W-1:0]          rtag_q [SETS][WAYS];
  logic [CTX_W-1:0]          ctx_q  [SETS][WAYS];

  // State bits: reset, written by all three operations.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      case (wr_op)
        TS_INVAL: begin
          valid_q[wr_set][wr_way] <= 1'b0;
          dirty_q[wr_set][wr_way] <= 1'b0;
        end
        TS_DIRTY: dirty_q[wr_set][wr_way] <= 1'b1;
        TS_INSTALL: begin
          valid_q[wr_set][wr_way] <= 1'b1;
          dirty_q[wr_set][wr_way] <= wr_dirty;
        end
        default: ;
      endcase
    end
  end

  // Tag payload: no reset, qualified by the valid bit.
  always_ff @(posedge clk) begin
    if (wr_op == TS_INSTALL) begin
      vtag_q[wr_set][wr_way] <= wr_vtag;
      rtag_q[wr_set][wr_way] <= wr_rtag;
      ctx_q[wr_set][wr_way]  <= wr_ctx;
    end
  end

  always_comb begin
    rd_valid = valid_q[rd_set];
    rd_dirty = dirty_q[rd_set];
    for (int w = 0; w < WAYS; w++) begin
      rd_vtag[w] = vtag_q[rd_set][w];
      rd_rtag[w] = rtag_q[rd_set][w];
      rd_ctx[w]  = ctx_q[rd_set][w];
    end
  end

endmodule

// File: rtl/vtag_way_match.sv
module vtag_way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 20,
  parameter int CTX_W = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]             rd_valid,
  input  logic [WAYS-1:0][TAG_W-1:0]  rd_vtag,
  input  logic [WAYS-1:0][TAG_W-1:0]  rd_rtag,
  input  logic [WAYS-1:0][CTX_W-1:0]  rd_ctx,
  input  logic [TAG_W-1:0]            key_vtag,
  input  logic [TAG_W-1:0]            key_rtag,
  input  logic [CTX_W-1:0]            key_ctx,
  output logic [WAYS-1:0]             hit_vec,
  output logic [WAYS-1:0]             alias_vec,
  output logic [WAYS-1:0]             ctx_vec,
  output logic [WAY_W-1:0]            hit_way,
  output logic [WAY_W-1:0]            alias_way,
  output logic [WAY_W-1:0]            ctx_way
);

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    logic ctx_eq;
    assign ctx_eq       = (rd_ctx[w] == key_ctx);
    assign hit_vec[w]   = rd_valid[w] && ctx_eq && (rd_vtag[w] == key_vtag);
    assign alias_vec[w] = rd_valid[w] && (rd_rtag[w] == key_rtag);
    assign ctx_vec[w]   = rd_valid[w] && ctx_eq;
  end

  // Lowest-index encoders.
  always_comb begin
    hit_way   = '0;
    alias_way = '0;
    ctx_way   = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (hit_vec[i])   hit_way   = WAY_W'(i);
      if (alias_vec[i]) alias_way = WAY_W'(i);
      if (ctx_vec[i])   ctx_way   = WAY_W'(i);
    end
  end

endmodule

// File: rtl/vtag_victim_sel.sv
module vtag_victim_sel #(
  parameter int WAYS  = 4,
  parameter int IDX_W = 7,
  localparam int SETS  = 1 << IDX_W,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] set,
  input  logic [WAYS-1:0]  valid_vec,
  input  logic             advance,
  output logic [WAY_W-1:0] victim
);

  logic [SETS-1:0][WAY_W-1:0] rr_q;
  logic [WAY_W-1:0]           first_free;
  logic                       any_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (advance) begin
      rr_q[set] <= rr_q[set] + 1'b1;
    end
  end

  always_comb begin
    first_free = '0;
    any_free   = 1'b0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        first_free = WAY_W'(i);
        any_free   = 1'b1;
      end
    end
    victim = any_free ? first_free : rr_q[set];
  end

endmodule

// File: rtl/vtag_alias_ctrl.sv
module vtag_alias_ctrl
  import vtag_pkg::*;
#(
  parameter int WAYS   = 4,
  parameter int ADDR_W = 32,
  parameter int CTX_W  = 8,
  parameter int OFF_W  = 5,
  parameter int IDX_W  = 7,
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [CTX_W-1:0]  req_ctx,
  input  logic              req_store,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [WAY_W-1:0]  resp_way,
  output logic              xlate_req,
  output logic [ADDR_W-1:0] xlate_vaddr,
  input  logic              xlate_ack,
  input  logic [ADDR_W-1:0] xlate_raddr,
  output logic              wb_req,
  output logic [ADDR_W-1:0] wb_raddr,
  input  logic              wb_ack,
  output logic              fill_req,
  output logic [ADDR_W-1:0] fill_raddr,
  output logic [WAY_W-1:0]  fill_way,
  input  logic              fill_ack,
  input  logic              flush_req,
  input  logic [CTX_W-1:0]  flush_ctx
);

  if (!(WAYS == 2 || WAYS == 4 || WAYS == 8)) begin : g_bad_ways
    $error("vtag_alias_ctrl: WAYS must be 2, 4 or 8");
  end

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_l;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_l = rst_pipe[1];

  ctl_state_t        state_q, state_d;
  logic [ADDR_W-1:0] vaddr_q, vaddr_d;
  logic [IDX_W-1:0]  set_q, set_d;
  logic [CTX_W-1:0]  ctx_q, ctx_d;
  logic              store_q, store_d;
  logic [TAG_W-1:0]  rtag_q, rtag_d;
  logic [WAY_W-1:0]  tgt_q, tgt_d;
  logic              alias_seen_q, alias_seen_d;
  logic [WAY_W-1:0]  alias_way_q, alias_way_d;
  logic              in_flush_q, in_flush_d;
  logic              rhit_q, rhit_d;
  logic [WAY_W-1:0]  rway_q, rway_d;

  logic [WAYS-1:0]             rd_valid, rd_dirty;
  logic [WAYS-1:0][TAG_W-1:0]  rd_vtag, rd_rtag;
  logic [WAYS-1:0][CTX_W-1:0]  rd_ctx;
  logic [WAYS-1:0]             hit_vec, alias_vec, ctx_vec;
  logic [WAY_W-1:0]            hit_way, alias_way, ctx_way, victim;
  ts_op_t                      ts_op;
  logic [WAY_W-1:0]            ts_way;
  logic                        rr_adv;
  logic [WAY_W-1:0]            fill_pick;

  vtag_tag_store #(.WAYS(WAYS), .IDX_W(IDX_W), .TAG_W(TAG_W), .CTX_W(CTX_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_l),
    .rd_set   (set_q),
    .rd_valid (rd_valid),
    .rd_dirty (rd_dirty),
    .rd_vtag  (rd_vtag),
    .rd_rtag  (rd_rtag),
    .rd_ctx   (rd_ctx),
    .wr_op    (ts_op),
    .wr_set   (set_q),
    .wr_way   (ts_way),
    .wr_vtag  (vaddr_q[ADDR_W-1 -: TAG_W]),
    .wr_rtag  (rtag_q),
    .wr_ctx   (ctx_q),
    .wr_dirty (store_q)
  );

  vtag_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .CTX_W(CTX_W)) u_match (
    .rd_valid  (rd_valid),
    .rd_vtag   (rd_vtag),
    .rd_rtag   (rd_rtag),
    .rd_ctx    (rd_ctx),
    .key_vtag  (vaddr_q[ADDR_W-1 -: TAG_W]),
    .key_rtag  (rtag_q),
    .key_ctx   (ctx_q),
    .hit_vec   (hit_vec),
    .alias_vec (alias_vec),
    .ctx_vec   (ctx_vec),
    .hit_way   (hit_way),
    .alias_way (alias_way),
    .ctx_way   (ctx_way)
  );

  vtag_victim_sel #(.WAYS(WAYS), .IDX_W(IDX_W)) u_victim (
    .clk       (clk),
    .rst_n     (rst_l),
    .set       (set_q),
    .valid_vec (rd_valid),
    .advance   (rr_adv),
    .victim    (victim)
  );

  assign fill_pick = alias_seen_q ? alias_way_q : victim;

  // Next-state logic.
  always_comb begin
    state_d      = state_q;
    vaddr_d      = vaddr_q;
    set_d        = set_q;
    ctx_d        = ctx_q;
    store_d      = store_q;
    rtag_d       = rtag_q;
    tgt_d        = tgt_q;
    alias_seen_d = alias_seen_q;
    alias_way_d  = alias_way_q;
    in_flush_d   = in_flush_q;
    rhit_d       = rhit_q;
    rway_d       = rway_q;
    ts_op        = TS_NONE;
    ts_way       = tgt_q;
    rr_adv       = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (flush_req) begin
          set_d      = '0;
          ctx_d      = flush_ctx;
          in_flush_d = 1'b1;
          state_d    = ST_FLUSH;
        end else if (req_valid) begin
          vaddr_d      = req_vaddr;
          set_d        = req_vaddr[OFF_W +: IDX_W];
          ctx_d        = req_ctx;
          store_d      = req_store;
          in_flush_d   = 1'b0;
          alias_seen_d = 1'b0;
          state_d      = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (|hit_vec) begin
          rhit_d = 1'b1;
          rway_d = hit_way;
          if (store_q) begin
            ts_op  = TS_DIRTY;
            ts_way = hit_way;
          end
          state_d = ST_DONE;
        end else begin
          state_d = ST_XLATE;
        end
      end
      ST_XLATE: begin
        if (xlate_ack) begin
          rtag_d  = xlate_raddr[ADDR_W-1 -: TAG_W];
          state_d = ST_ALIAS;
        end
      end
      ST_ALIAS: begin
        if (|alias_vec) begin
          alias_seen_d = 1'b1;
          alias_way_d  = alias_way;
          if (rd_dirty[alias_way]) begin
            tgt_d   = alias_way;
            state_d = ST_WB;
          end else begin
            ts_op  = TS_INVAL;
            ts_way = alias_way;
          end
        end else begin
          tgt_d   = fill_pick;
          state_d = (rd_valid[fill_pick] && rd_dirty[fill_pick]) ? ST_WB : ST_FILL;
        end
      end
      ST_WB: begin
        if (wb_ack) begin
          ts_op   = TS_INVAL;
          state_d = in_flush_q ? ST_FLUSH : ST_ALIAS;
        end
      end
      ST_FILL: begin
        if (fill_ack) begin
          ts_op   = TS_INSTALL;
          rr_adv  = 1'b1;
          rhit_d  = 1'b0;
          rway_d  = tgt_q;
          state_d = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      ST_FLUSH: begin
        if (|ctx_vec) begin
          if (rd_dirty[ctx_way]) begin
            tgt_d   = ctx_way;
            state_d = ST_WB;
          end else begin
            ts_op  = TS_INVAL;
            ts_way = ctx_way;
          end
        end else if (&set_q) begin
          in_flush_d = 1'b0;
          state_d    = ST_IDLE;
        end else begin
          set_d = set_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // State register.
  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      state_q      <= ST_IDLE;
      in_flush_q   <= 1'b0;
      alias_seen_q <= 1'b0;
      rhit_q       <= 1'b0;
    end else begin
      state_q      <= state_d;
      in_flush_q   <= in_flush_d;
      alias_seen_q <= alias_seen_d;
      rhit_q       <= rhit_d;
    end
  end

  // Datapath registers: no reset, loaded only when the FSM consumes them.
  always_ff @(posedge clk) begin
    vaddr_q     <= vaddr_d;
    set_q       <= set_d;
    ctx_q       <= ctx_d;
    store_q     <= store_d;
    rtag_q      <= rtag_d;
    tgt_q       <= tgt_d;
    alias_way_q <= alias_way_d;
    rway_q      <= rway_d;
  end

  assign req_ready   = rst_l && (state_q == ST_IDLE) && !flush_req;
  assign resp_valid  = (state_q == ST_DONE);
  assign resp_hit    = rhit_q;
  assign resp_way    = rway_q;
  assign xlate_req   = (state_q == ST_XLATE);
  assign xlate_vaddr = vaddr_q;
  assign wb_req      = (state_q == ST_WB);
  assign wb_raddr    = {rd_rtag[tgt_q], set_q, {OFF_W{1'b0}}};
  assign fill_req    = (state_q == ST_FILL);
  assign fill_raddr  = {rtag_q, set_q, {OFF_W{1'b0}}};
  assign fill_way    = tgt_q;

  // Assertions.
  a_r2_single_hit: assert property (@(posedge clk) disable iff (!rst_l)
    (state_q == ST_LOOKUP) |-> $onehot0(hit_vec));

  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_l)
    (req_valid && req_ready) |=> !req_ready);

  a_r4_xlate_hold: assert property (@(posedge clk) disable iff (!rst_l)
    (xlate_req && !xlate_ack) |=> (xlate_req && $stable(xlate_vaddr)));

  a_r6_wb_hold: assert property (@(posedge clk) disable iff (!rst_l)
    (wb_req && !wb_ack) |=> (wb_req && $stable(wb_raddr)));

  a_r11_fill_hold: assert property (@(posedge clk) disable iff (!rst_l)
    (fill_req && !fill_ack) |=> (fill_req && $stable(fill_raddr) && $stable(fill_way)));

  a_r5_no_alias_at_fill: assert property (@(posedge clk) disable iff (!rst_l)
    (fill_req && fill_ack) |-> ($countones(alias_vec) == 0));

endmodule

// File: tb/vtag_alias_ctrl_bench.sv
module vtag_alias_ctrl_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_store, flush_req;
  logic [31:0] req_vaddr;
  logic [7:0]  req_ctx, flush_ctx;
  logic        req_ready, resp_valid, resp_hit;
  logic [1:0]  resp_way, fill_way;
  logic        xlate_req, xlate_ack, wb_req, wb_ack, fill_req, fill_ack;
  logic [31:0] xlate_vaddr, wb_raddr, fill_raddr;
  logic [31:0] cur_ra, cur_va;
  logic [1:0]  cur_way;

  int n_chk = 0;
  int n_bad = 0;
  int resp_cnt = 0;
  int lat = 0;
  logic [2:0]  exp_q[$];
  logic [31:0] wb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vtag_alias_ctrl u_vtag_alias_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_ctx(req_ctx), .req_store(req_store),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_way(resp_way),
    .xlate_req(xlate_req), .xlate_vaddr(xlate_vaddr), .xlate_ack(xlate_ack),
    .xlate_raddr(cur_ra),
    .wb_req(wb_req), .wb_raddr(wb_raddr), .wb_ack(wb_ack),
    .fill_req(fill_req), .fill_raddr(fill_raddr), .fill_way(fill_way),
    .fill_ack(fill_ack),
    .flush_req(flush_req), .flush_ctx(flush_ctx)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [19:0] t, input logic [6:0] s, input logic [4:0] o);
    return {t, s, o};
  endfunction

  // Monitor and memory-side responder.
  always @(negedge clk) begin
    xlate_ack = 1'b0;
    wb_ack    = 1'b0;
    fill_ack  = 1'b0;
    if (rst_n) begin
      if (resp_valid) begin
        if (exp_q.size() == 0) chk(0, "R2 unexpected response", {31'd0, resp_hit}, 32'd0);
        else begin
          logic [2:0] e;
          e = exp_q.pop_front();
          chk({resp_hit, resp_way} == e, e[2] ? "R2 hit response" : "R11 miss response",
              {29'd0, resp_hit, resp_way}, {29'd0, e});
        end
        resp_cnt++;
      end
      if (xlate_req || wb_req || fill_req) lat++;
      else lat = 0;
      if (lat == 2) begin
        lat = 0;
        if (xlate_req) begin
          chk(xlate_vaddr == cur_va, "R4 translation address", xlate_vaddr, cur_va);
          xlate_ack = 1'b1;
        end
        if (wb_req) begin
          if (wb_q.size() == 0) chk(0, "R6 unexpected write-back", wb_raddr, 32'd0);
          else begin
            logic [31:0] w;
            w = wb_q.pop_front();
            chk(wb_raddr == w, "R6 write-back address", wb_raddr, w);
          end
          wb_ack = 1'b1;
        end
        if (fill_req) begin
          chk(fill_raddr == {cur_ra[31:5], 5'd0}, "R11 fill address", fill_raddr, {cur_ra[31:5], 5'd0});
          chk(fill_way == cur_way, "R7 fill way", {30'd0, fill_way}, {30'd0, cur_way});
          fill_ack = 1'b1;
        end
      end
    end
  end

  // Driver: pushes the expected response, then issues the request.
  task automatic access(input logic [31:0] va, input logic [7:0] cx, input logic st,
                        input logic [31:0] ra, input logic eh, input logic [1:0] ew);
    int n0;
    exp_q.push_back({eh, ew});
    cur_va  = va;
    cur_ra  = ra;
    cur_way = ew;
    @(negedge clk);
    req_vaddr = va; req_ctx = cx; req_store = st; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    n0 = resp_cnt;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R9 ready low while busy", {31'd0, req_ready}, 32'd0);
    while (resp_cnt == n0) @(negedge clk);
  endtask

  task automatic do_flush(input logic [7:0] cx);
    @(negedge clk);
    flush_ctx = cx; flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;
    chk(!req_ready, "R9 ready low during flush", {31'd0, req_ready}, 32'd0);
    while (!req_ready) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_store = 1'b0; flush_req = 1'b0;
    req_vaddr = '0; req_ctx = '0; flush_ctx = '0; cur_ra = '0; cur_va = '0; cur_way = '0;
    xlate_ack = 1'b0; wb_ack = 1'b0; fill_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready && !resp_valid && !xlate_req && !wb_req && !fill_req, "R9 reset state",
        {27'd0, req_ready, resp_valid, xlate_req, wb_req, fill_req}, 32'h10);

    // R7: empty set fills the lowest invalid way; R11 fill fields.
    access(mk(20'h10, 7'd3, 5'd0), 8'd1, 1'b0, mk(20'h100, 7'd3, 5'd0), 1'b0, 2'd0);
    // R1: offset bits ignored.
    access(mk(20'h10, 7'd3, 5'h1f), 8'd1, 1'b0, mk(20'h100, 7'd3, 5'd0), 1'b1, 2'd0);
    // R3: same address, other context -> separate entry.
    access(mk(20'h10, 7'd3, 5'd0), 8'd2, 1'b0, mk(20'h200, 7'd3, 5'd0), 1'b0, 2'd1);
    access(mk(20'h10, 7'd3, 5'd4), 8'd1, 1'b0, mk(20'h100, 7'd3, 5'd0), 1'b1, 2'd0);
    access(mk(20'h10, 7'd3, 5'd4), 8'd2, 1'b0, mk(20'h200, 7'd3, 5'd0), 1'b1, 2'd1);
    // R1: index bits select another set.
    access(mk(20'h10, 7'd4, 5'd0), 8'd1, 1'b0, mk(20'h300, 7'd4, 5'd0), 1'b0, 2'd0);
    // R8: store hit marks way 0 dirty.
    access(mk(20'h10, 7'd3, 5'd8), 8'd1, 1'b1, mk(20'h100, 7'd3, 5'd0), 1'b1, 2'd0);
    // R5/R6: dirty alias written back and its way reused.
    wb_q.push_back(mk(20'h100, 7'd3, 5'd0));
    access(mk(20'h55, 7'd3, 5'd0), 8'd1, 1'b0, mk(20'h100, 7'd3, 5'd0), 1'b0, 2'd0);
    // R5: clean alias dropped without write-back.
    access(mk(20'h10, 7'd3, 5'd0), 8'd1, 1'b0, mk(20'h100, 7'd3, 5'd0), 1'b0, 2'd0);
    chk(wb_q.size() == 0, "R6 clean alias no write-back", wb_q.size(), 32'd0);
    // R7: fill remaining ways, then round robin (pointer at 2 after six fills).
    access(mk(20'h20, 7'd3, 5'd0), 8'd1, 1'b0, mk(20'h400, 7'd3, 5'd0), 1'b0, 2'd2);
    access(mk(20'h21, 7'd3, 5'd0), 8'd1, 1'b0, mk(20'h401, 7'd3, 5'd0), 1'b0, 2'd3);
    access(mk(20'h30, 7'd3, 5'd0), 8'd1, 1'b0, mk(20'h500, 7'd3, 5'd0), 1'b0, 2'd2);
    // R8 then R6: dirty round-robin victim is written back.
    access(mk(20'h21, 7'd3, 5'd0), 8'd1, 1'b1, mk(20'h401, 7'd3, 5'd0), 1'b1, 2'd3);
    wb_q.push_back(mk(20'h401, 7'd3, 5'd0));
    access(mk(20'h31, 7'd3, 5'd0), 8'd1, 1'b0, mk(20'h501, 7'd3, 5'd0), 1'b0, 2'd3);
    // R10: flush context 2 (its line dirty), others kept.
    access(mk(20'h10, 7'd3, 5'd0), 8'd2, 1'b1, mk(20'h200, 7'd3, 5'd0), 1'b1, 2'd1);
    wb_q.push_back(mk(20'h200, 7'd3, 5'd0));
    do_flush(8'd2);
    chk(wb_q.size() == 0, "R10 flush wrote back dirty line", wb_q.size(), 32'd0);
    access(mk(20'h10, 7'd3, 5'd0), 8'd1, 1'b0, mk(20'h100, 7'd3, 5'd0), 1'b1, 2'd0);
    access(mk(20'h10, 7'd4, 5'd0), 8'd1, 1'b0, mk(20'h300, 7'd4, 5'd0), 1'b1, 2'd0);
    // R10: flushed entry now misses; R7 refills the freed way 1.
    access(mk(20'h10, 7'd3, 5'd0), 8'd2, 1'b0, mk(20'h600, 7'd3, 5'd0), 1'b0, 2'd1);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all responses seen", exp_q.size(), 32'd0);
    chk(wb_q.size() == 0, "R6 all write-backs seen", wb_q.size(), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule